// File: doc/BRIEF.md
# SPI NAND Parameter Page Fetcher

This block talks to a serial NAND flash device over a single-bit SPI link and copies the device's parameter page into a local byte buffer. A one-cycle `start` pulse launches a fixed command sequence. The block first reads the configuration feature register and issues a write-enable. It then sets the identification-read bit and reads the register back to confirm that the bit took effect. Next it loads the special parameter row into the device cache and polls the status register until the device is idle. Finally it streams three back-to-back copies of the page out of the cache, burst by burst, into the buffer.

The identification-read bit is always cleared again once the page load has been issued, on the success path and after a poll timeout alike. If the read-back shows that the bit did not set, the block stops at once and reports an error. No page load and no restore follow in that case. A host waits for `done`, checks `err`, and then reads the buffer, which holds the copies in stream order.

Top module: `nand_pp_fetch`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `err` and `buf_we` are all 0.
- R2: The link runs in SPI mode 0. `sclk` idles low and is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. `miso` is sampled on the rising `sclk` edge. Bytes go most significant bit first. `cs_n` returns high between any two commands.
- R3: The first four commands are, in order: get-feature `0F B0 xx`, which reads the configuration value C; write-enable `06`; set-feature `1F B0 (C|40h)`; and get-feature `0F B0 xx` again, which reads the value V back.
- R4: If bit 6 of V is 0, `err` is raised and `done` pulses, and no further command is issued (no page load and no restore).
- R5: If bit 6 of V is 1, the next command is the page load `13 00 00 01` (opcode followed by the 24-bit row address 1).
- R6: The block then polls status with `0F C0 xx` while bit 0 of the returned byte is 1. Once bit 0 reads 0, it proceeds to the cache reads. If `poll_limit` polls (a value of 0 counts as 1) all return busy, it raises `err` and goes straight to the restore.
- R7: Each cache read is `03`, column high byte, column low byte and one dummy byte, followed by min(BURST_BYTES, remaining) data bytes. The column equals the number of bytes already read, starting at 0. The total is COPIES x COPY_BYTES bytes (768 by default).
- R8: Data byte k of the stream is written once to buffer address k with a one-cycle `buf_we`, in increasing order. No writes occur on an error path.
- R9: The last command is set-feature `1F B0 (V & ~40h)`. It is issued after the final cache read and also after a poll timeout.
- R10: `done` is a one-cycle pulse, and in that cycle `busy` is low. `busy` stays high from the cycle after `start` until `done`. `err` holds its value until the next accepted start. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse, accepted when idle |
| poll_limit | input | 16 | Maximum number of status polls, captured at start |
| sclk | output | 1 | SPI clock, mode 0 |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 10 | Buffer byte address |
| buf_data | output | 8 | Buffer write data |
| done | output | 1 | Sequence finished, one-cycle pulse |
| err | output | 1 | Sequence failed (verify or poll timeout) |
| busy | output | 1 | Sequence in progress |

## Verification
Most faults in the sequencer show up on the SPI pins within one command. A wrong state, a miscounted byte index or a bad column register changes the opcode, the address bytes or the length of a chip-select frame. The command scoreboard flags that at the rising edge of `cs_n` that closes the frame. A wrong read-count or address register shows up as an out-of-order or misdirected buffer write on the very cycle of the write. Faults in the verify, timeout or restore decisions appear as a missing or extra frame and a wrong `err` level at the `done` pulse.

// File: rtl/nand_pp_pkg.sv
// Shared constants and types for the parameter page fetcher.
// Assumes single-bit SPI and the fixed feature register addresses below.
package nand_pp_pkg;

    localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
    localparam logic [7:0] OP_SET_FEAT  = 8'h1F;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
    localparam logic [7:0] OP_CACHE_RD  = 8'h03;
    localparam logic [7:0] FR_CONFIG    = 8'hB0;
    localparam logic [7:0] FR_STATUS    = 8'hC0;
    localparam logic [7:0] ID_READ_BIT  = 8'h40;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GETCFG,
        ST_WREN,
        ST_SETCFG,
        ST_CHKCFG,
        ST_LOAD,
        ST_POLL,
        ST_READ,
        ST_RESTORE,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/nand_spi_shifter.sv
// Full-duplex one-byte SPI mode 0 shifter.
// Loads a byte on go, shifts it MSB first, samples miso on each rising sclk
// edge and pulses fin after the eighth falling edge. Assumes go only while idle.
module nand_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       fin
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic          active;
    logic [7:0]    sh;
    logic [2:0]    bitn;
    logic [CW-1:0] cnt;

    // Shift one byte out and one byte in, paced by the half-period divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sh     <= '0;
            rx     <= '0;
            bitn   <= '0;
            cnt    <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= tx;
                    mosi   <= tx[7];
                    bitn   <= '0;
                    cnt    <= '0;
                    sclk   <= 1'b0;
                end
            end else if (cnt == CW'(HALF_DIV - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                        mosi <= sh[6];
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R2: data out must not move while the clock is high
    a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(mosi)));
    // R2: a finished byte leaves the clock at its idle level
    a_r2_fin_low: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !sclk);

endmodule

// File: rtl/nand_pp_seq.sv
// Command sequencer for the parameter page fetch.
// Frames each command with cs_n, feeds bytes to the shifter, decides the next
// command from returned bytes and writes cache data to the buffer.
// Assumes TOTAL fits in 16 column bits.
module nand_pp_seq
    import nand_pp_pkg::*;
#(
    parameter int TOTAL       = 768,
    parameter int BURST_BYTES = 128,
    parameter int GAP_CYC     = 2,
    parameter int PL_W        = 16,
    parameter int AW          = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PL_W-1:0] poll_limit,
    input  logic            fin,
    input  logic [7:0]      rx,
    output logic            go,
    output logic [7:0]      tx,
    output logic            cs_n,
    output logic            buf_we,
    output logic [AW-1:0]   buf_addr,
    output logic [7:0]      buf_data,
    output logic            done,
    output logic            err,
    output logic            busy
);
    localparam int IDX_W = $clog2(BURST_BYTES + 5);
    localparam int GW    = $clog2(GAP_CYC + 1);

    seq_state_t      state;
    logic            xfer;
    logic [GW-1:0]   gap_cnt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [7:0]      cfg;
    logic [PL_W-1:0] polls;
    logic [PL_W-1:0] limit;
    logic [AW-1:0]   rd_cnt;
    logic [AW-1:0]   base;
    logic [AW-1:0]   rd_nxt;
    logic            rd_done;
    logic [AW:0]     remain;
    logic [AW:0]     blen;
    logic [PL_W:0]   poll_nxt;
    logic [PL_W:0]   lim_eff;
    logic [15:0]     col;

    // Derived counts: burst length, end-of-stream and poll limit.
    always_comb begin
        remain   = (AW+1)'(TOTAL) - {1'b0, base};
        blen     = (remain < (AW+1)'(BURST_BYTES)) ? remain : (AW+1)'(BURST_BYTES);
        rd_nxt   = rd_cnt + AW'(1);
        rd_done  = ({1'b0, rd_cnt} + (AW+1)'(1)) == (AW+1)'(TOTAL);
        poll_nxt = {1'b0, polls} + (PL_W+1)'(1);
        lim_eff  = (limit == '0) ? (PL_W+1)'(1) : {1'b0, limit};
        col      = 16'(base);
    end

    // Index of the final byte of the current command.
    always_comb begin
        case (state)
            ST_WREN: last_idx = IDX_W'(0);
            ST_LOAD: last_idx = IDX_W'(3);
            ST_READ: last_idx = IDX_W'(3) + IDX_W'(blen);
            default: last_idx = IDX_W'(2);
        endcase
    end

    // Byte to transmit for the current command and byte index.
    always_comb begin
        tx = 8'h00;
        case (state)
            ST_GETCFG, ST_CHKCFG:
                case (idx)
                    IDX_W'(0): tx = OP_GET_FEAT;
                    IDX_W'(1): tx = FR_CONFIG;
                    default:   tx = 8'h00;
                endcase
            ST_WREN: tx = OP_WR_EN;
            ST_SETCFG:
                case (idx)
                    IDX_W'(0): tx = OP_SET_FEAT;
                    IDX_W'(1): tx = FR_CONFIG;
                    default:   tx = cfg | ID_READ_BIT;
                endcase
            ST_RESTORE:
                case (idx)
                    IDX_W'(0): tx = OP_SET_FEAT;
                    IDX_W'(1): tx = FR_CONFIG;
                    default:   tx = cfg & ~ID_READ_BIT;
                endcase
            ST_LOAD:
                case (idx)
                    IDX_W'(0): tx = OP_PAGE_LOAD;
                    IDX_W'(3): tx = 8'h01;
                    default:   tx = 8'h00;
                endcase
            ST_POLL:
                case (idx)
                    IDX_W'(0): tx = OP_GET_FEAT;
                    IDX_W'(1): tx = FR_STATUS;
                    default:   tx = 8'h00;
                endcase
            ST_READ:
                case (idx)
                    IDX_W'(0): tx = OP_CACHE_RD;
                    IDX_W'(1): tx = col[15:8];
                    IDX_W'(2): tx = col[7:0];
                    default:   tx = 8'h00;
                endcase
            default: tx = 8'h00;
        endcase
    end

    // Main sequence: framing, byte stepping, capture and branching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            xfer     <= 1'b0;
            gap_cnt  <= '0;
            idx      <= '0;
            cfg      <= '0;
            polls    <= '0;
            limit    <= '0;
            rd_cnt   <= '0;
            base     <= '0;
            go       <= 1'b0;
            cs_n     <= 1'b1;
            buf_we   <= 1'b0;
            buf_addr <= '0;
            buf_data <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            busy     <= 1'b0;
        end else begin
            go     <= 1'b0;
            buf_we <= 1'b0;
            done   <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    busy    <= 1'b1;
                    err     <= 1'b0;
                    limit   <= poll_limit;
                    polls   <= '0;
                    rd_cnt  <= '0;
                    base    <= '0;
                    xfer    <= 1'b0;
                    gap_cnt <= '0;
                    state   <= ST_GETCFG;
                end
            end else if (state == ST_FIN) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
            end else if (!xfer) begin
                if (gap_cnt == GW'(GAP_CYC - 1)) begin
                    gap_cnt <= '0;
                    xfer    <= 1'b1;
                    cs_n    <= 1'b0;
                    idx     <= '0;
                    go      <= 1'b1;
                end else begin
                    gap_cnt <= gap_cnt + GW'(1);
                end
            end else if (fin) begin
                if (state == ST_READ && idx >= IDX_W'(4)) begin
                    buf_we   <= 1'b1;
                    buf_addr <= rd_cnt;
                    buf_data <= rx;
                    rd_cnt   <= rd_nxt;
                end
                if (idx != last_idx) begin
                    idx <= idx + IDX_W'(1);
                    go  <= 1'b1;
                end else begin
                    cs_n    <= 1'b1;
                    xfer    <= 1'b0;
                    gap_cnt <= '0;
                    case (state)
                        ST_GETCFG: begin
                            cfg   <= rx;
                            state <= ST_WREN;
                        end
                        ST_WREN:   state <= ST_SETCFG;
                        ST_SETCFG: state <= ST_CHKCFG;
                        ST_CHKCFG: begin
                            cfg <= rx;
                            if (rx[6]) begin
                                state <= ST_LOAD;
                            end else begin
                                err   <= 1'b1;
                                state <= ST_FIN;
                            end
                        end
                        ST_LOAD: state <= ST_POLL;
                        ST_POLL: begin
                            if (!rx[0]) begin
                                state <= ST_READ;
                            end else if (poll_nxt >= lim_eff) begin
                                err   <= 1'b1;
                                state <= ST_RESTORE;
                            end else begin
                                polls <= polls + PL_W'(1);
                            end
                        end
                        ST_READ: begin
                            if (rd_done) state <= ST_RESTORE;
                            else         base  <= rd_nxt;
                        end
                        default: state <= ST_FIN;
                    endcase
                end
            end
        end
    end

    // R10: done lasts exactly one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: done coincides with the end of busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: buffer writes happen only during a run and inside the buffer
    a_r8_we_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (busy && (buf_addr < AW'(TOTAL))));
    // R6: the poll count never reaches the effective limit
    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, polls} < lim_eff));

endmodule

// File: rtl/nand_pp_fetch.sv
// Top of the SPI NAND parameter page fetcher.
// Joins the command sequencer to the byte shifter. Assumes one device,
// single-bit SPI mode 0 and a buffer that accepts one byte per write strobe.
module nand_pp_fetch #(
    parameter int HALF_DIV    = 2,
    parameter int GAP_CYC     = 2,
    parameter int COPY_BYTES  = 256,
    parameter int COPIES      = 3,
    parameter int BURST_BYTES = 128,
    parameter int PL_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PL_W-1:0] poll_limit,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi,
    input  logic            miso,
    output logic            buf_we,
    output logic [$clog2(COPY_BYTES*COPIES)-1:0] buf_addr,
    output logic [7:0]      buf_data,
    output logic            done,
    output logic            err,
    output logic            busy
);
    localparam int TOTAL = COPY_BYTES * COPIES;
    localparam int AW    = $clog2(TOTAL);

    logic       go;
    logic [7:0] tx;
    logic [7:0] rx;
    logic       fin;

    nand_pp_seq #(
        .TOTAL(TOTAL), .BURST_BYTES(BURST_BYTES), .GAP_CYC(GAP_CYC),
        .PL_W(PL_W), .AW(AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
        .fin(fin), .rx(rx), .go(go), .tx(tx), .cs_n(cs_n),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .done(done), .err(err), .busy(busy)
    );

    nand_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .tx(tx), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx(rx), .fin(fin)
    );

    // R2: the clock stays idle whenever the device is deselected
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R1: nothing is written to the buffer while idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !buf_we);

endmodule

// File: tb/sim_nand_pp_fetch.sv
`timescale 1ns/1ps
module sim_nand_pp_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] poll_limit = 16'd0;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic        buf_we;
    logic [9:0]  buf_addr;
    logic [7:0]  buf_data;
    logic        done, err, busy;

    always #2 clk = ~clk;

    nand_pp_fetch u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
        .done(done), .err(err), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + (a >> 8) * 11 + 5);
    endfunction

    // ---------------- device model ----------------
    logic [7:0] m_cfg = 8'h00;
    bit         m_lock = 1'b0;
    int         m_busy_set = 0;
    int         m_busy_left = 0;
    logic [7:0] m_bytes [8];
    logic [7:0] m_cur = 8'h00;
    int         m_bits = 0;
    int         sclk_bad = 0;

    function automatic logic [7:0] resp(input int k);
        if (m_bytes[0] == 8'h0F && k == 2) begin
            if (m_bytes[1] == 8'hB0) return m_cfg;
            if (m_bytes[1] == 8'hC0) return {7'd0, m_busy_left > 0};
            return 8'h00;
        end
        if (m_bytes[0] == 8'h03 && k >= 4)
            return pat(int'({m_bytes[1], m_bytes[2]}) + k - 4);
        return 8'h00;
    endfunction

    always @(negedge cs_n) begin
        m_bits = 0;
        for (int i = 0; i < 8; i++) m_bytes[i] = 8'h00;
        miso = 1'b0;
    end

    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            m_cur = {m_cur[6:0], mosi};
            m_bits++;
            if (m_bits % 8 == 0 && m_bits / 8 <= 8) m_bytes[m_bits/8 - 1] = m_cur;
        end
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            logic [7:0] r;
            r = resp(m_bits / 8);
            miso = r[7 - (m_bits % 8)];
        end
    end

    // R2: clock must idle low while deselected
    always @(negedge clk) begin
        if (rst_n && cs_n === 1'b1 && sclk !== 1'b0) sclk_bad++;
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_hdr [$];
    int          exp_len [$];

    task automatic push_cmd(input logic [31:0] hdr, input int len);
        exp_hdr.push_back(hdr);
        exp_len.push_back(len);
    endtask

    // Monitor: apply command effects and compare each frame with the queue.
    always @(posedge cs_n) begin
        if (m_bits > 0) begin
            int          nb;
            logic [31:0] hdr;
            nb  = m_bits / 8;
            hdr = {m_bytes[0], m_bytes[1], m_bytes[2], m_bytes[3]};
            if (exp_hdr.size() == 0) begin
                check(1'b0, "R4/R9 unexpected command", hdr, 32'h0);
            end else begin
                logic [31:0] eh;
                int          el;
                eh = exp_hdr.pop_front();
                el = exp_len.pop_front();
                check(hdr == eh, "R3/R5/R6/R7/R9 command bytes", hdr, eh);
                check(nb == el && m_bits % 8 == 0, "R7 command length",
                      32'(m_bits), 32'(el * 8));
            end
            if (m_bytes[0] == 8'h1F && m_bytes[1] == 8'hB0)
                m_cfg = m_lock ? ((m_bytes[2] & 8'hBF) | (m_cfg & 8'h40)) : m_bytes[2];
            if (m_bytes[0] == 8'h13) m_busy_left = m_busy_set;
            if (m_bytes[0] == 8'h0F && m_bytes[1] == 8'hC0 && m_busy_left > 0)
                m_busy_left--;
        end
    end

    // R8: buffer write monitor
    int wr_cnt = 0;
    int wr_bad = 0;
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            if (int'(buf_addr) != wr_cnt || buf_data != pat(wr_cnt)) wr_bad++;
            wr_cnt++;
        end
    end

    // ---------------- driver ----------------
    task automatic run_case(input logic [7:0] cfg0, input bit lock,
                            input int bpolls, input int lim, input bit poke);
        logic [7:0] rb;
        bit         exp_err;
        int         exp_wr;
        int         l_eff;
        bit         got;
        m_cfg = cfg0; m_lock = lock; m_busy_set = bpolls; m_busy_left = 0;
        wr_cnt = 0; wr_bad = 0;
        rb     = lock ? cfg0 : (cfg0 | 8'h40);
        l_eff  = (lim == 0) ? 1 : lim;
        exp_wr = 0;
        push_cmd({8'h0F, 8'hB0, 16'h0}, 3);
        push_cmd({8'h06, 24'h0}, 1);
        push_cmd({8'h1F, 8'hB0, cfg0 | 8'h40, 8'h0}, 3);
        push_cmd({8'h0F, 8'hB0, 16'h0}, 3);
        if (!rb[6]) begin
            exp_err = 1'b1;
        end else begin
            push_cmd(32'h13000001, 4);
            if (bpolls >= l_eff) begin
                for (int i = 0; i < l_eff; i++) push_cmd({8'h0F, 8'hC0, 16'h0}, 3);
                exp_err = 1'b1;
            end else begin
                for (int i = 0; i <= bpolls; i++) push_cmd({8'h0F, 8'hC0, 16'h0}, 3);
                for (int c = 0; c < 768; c += 128)
                    push_cmd({8'h03, 16'(c), 8'h00}, 4 + 128);
                exp_err = 1'b0;
                exp_wr  = 768;
            end
            push_cmd({8'h1F, 8'hB0, rb & 8'hBF, 8'h0}, 3);
        end
        @(negedge clk);
        poll_limit = 16'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", 32'(busy), 32'h1);
        if (poke) begin
            repeat (500) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        got = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (done) begin got = 1'b1; break; end
        end
        check(got, "R10 done reached", 32'(got), 32'h1);
        check(err == exp_err, "R4/R6 err at done", 32'(err), 32'(exp_err));
        check(busy == 1'b0, "R10 busy low at done", 32'(busy), 32'h0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 32'(done), 32'h0);
        check(err == exp_err, "R10 err held", 32'(err), 32'(exp_err));
        check(exp_hdr.size() == 0, "R4/R9 missing commands",
              32'(exp_hdr.size()), 32'h0);
        check(wr_cnt == exp_wr, "R8 write count", 32'(wr_cnt), 32'(exp_wr));
        check(wr_bad == 0, "R8 write order/data", 32'(wr_bad), 32'h0);
        if (!lock && rb[6])
            check(m_cfg[6] == 1'b0, "R9 id-read bit restored", 32'(m_cfg), 32'(cfg0));
        exp_hdr.delete();
        exp_len.delete();
        repeat (10) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10 act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 32'h1);
        check(sclk == 1'b0, "R1 sclk", 32'(sclk), 32'h0);
        check({busy, done, err, buf_we} == 4'b0, "R1 status outputs",
              32'({busy, done, err, buf_we}), 32'h0);
        // success, device idle at once
        run_case(8'h11, 1'b0, 0, 4, 1'b0);
        // success after three busy polls; extra start while busy ignored (R10)
        run_case(8'hA2, 1'b0, 3, 8, 1'b1);
        // R4: bit refuses to set, abort before load
        run_case(8'h05, 1'b1, 0, 4, 1'b0);
        // bit already set on a locked device; busy polls one below the limit (R6 boundary)
        run_case(8'h40, 1'b1, 2, 3, 1'b0);
        // R6 timeout after the limit, then restore (R9)
        run_case(8'h00, 1'b0, 5, 3, 1'b0);
        // R6 limit of zero acts as one poll
        run_case(8'h80, 1'b0, 1, 0, 1'b0);
        check(sclk_bad == 0, "R2 sclk idle while deselected", 32'(sclk_bad), 32'h0);
        finish_run();
    end
endmodule